// File: doc/BRIEF.md
# Multi-Channel Timer Unit Register Decoder

This block is the register front end of a small timer unit. It holds two or three down-counting timer channels, a shared run-control register and an optional one-bit output-control register, all decoded from one byte-addressed space. Each access is steered to one channel's register window, and the address is rebased to that window. One interrupt line per channel and one run line per channel are brought out.

Each channel counts down by one every clock while its run bit is set. When it reaches zero it reloads from its period register and sets a sticky underflow flag. That flag raises the channel interrupt when the channel's interrupt enable is set. A build parameter picks the full configuration, with three channels and the output-control register, or the reduced one, with two channels and neither of the extras. In the reduced build, accesses to the missing resources are reported on an error output.

Top module: `tmu_unit`

## Requirements
- R1: After reset the run register reads 0, all run and interrupt outputs are 0, the output-control output is 0, and every channel's period and count registers read 0xFFFFFFFF.
- R2: In the full build, byte 0x00 is the output-control register. Only bit 0 is stored, and it drives `outctl_o`. Reads return that bit with all other bits 0.
- R3: Byte 0x04 is the run register. Bit i of it drives `run_o[i]`. A read returns the last accepted written value of bits 2:0, with all other bits 0.
- R4: The channel windows start at bytes 0x08, 0x14 and 0x20. The highest base at or below the address wins. Within a window, word offset 0 is the period, 4 is the count and 8 is the control register. Offset 0x0C is a capture data register that exists only on channel 2.
- R5: A running channel decrements its count once per clock. On a clock where the count is 0 it loads the period instead and sets the underflow flag, which is control bit 8.
- R6: Clearing a run bit freezes that channel's count. Setting the run bit again resumes counting from the frozen value.
- R7: A channel's interrupt is high exactly when its underflow flag and its interrupt enable (control bit 5) are both 1. A control write with bit 8 = 0 clears the flag, and a control write with bit 8 = 1 leaves it unchanged. All other control bits read 0.
- R8: If an underflow and a control write that clears the flag fall in the same clock, the flag ends up set.
- R9: A write to the count register of a running channel takes effect in place of that clock's decrement.
- R10: In the reduced build, any access at or above 0x20, any access to 0x00, and a run write with bit 2 set are errors. An erroneous run write leaves the run register unchanged.
- R11: An access that maps to no register, including channel 2 offsets at 0x10 and above, returns read data 0 and pulses `rsp_err` high for one cycle.
- R12: Read responses are registered. `rsp_valid`, `rsp_rdata` and `rsp_err` appear in the cycle after the request. A read returns the value the register held before the request's clock edge. Writes do not raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | One-cycle pulse for an invalid access |
| run_o | output | 3 | Per-channel run enable |
| irq_o | output | 3 | Per-channel interrupt |
| outctl_o | output | 1 | Output-control bit |

## Verification
Two things inside a channel can land on the same clock edge. The first pair is a count underflow and a control write that clears the underflow flag. The second pair is a count write and that clock's decrement. The bench loads a small count and starts the channel, then counts edges exactly so that the clearing control write, or the count write, falls on the edge where the counter reaches zero or decrements. The flag is judged through the interrupt pin and a control read-back, where it must remain set. The count is judged through a count read-back, which must hold the written value.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int MAX_CH   = 3;
    localparam int FLAG_BIT = 8;
    localparam int IE_BIT   = 5;

    localparam logic [ADDR_W-1:0] BASE_CH0 = 8'h08;
    localparam logic [ADDR_W-1:0] BASE_CH1 = 8'h14;
    localparam logic [ADDR_W-1:0] BASE_CH2 = 8'h20;
    localparam logic [ADDR_W-1:0] CH2_SPAN = 8'h10;
    localparam logic [ADDR_W-1:0] WIN_SPAN = 8'h0C;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_OUTCTL,
        TGT_RUN,
        TGT_CHAN
    } tgt_e;

    typedef enum logic [1:0] {
        REG_PERIOD  = 2'd0,
        REG_COUNT   = 2'd1,
        REG_CTRL    = 2'd2,
        REG_CAPTURE = 2'd3
    } chreg_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [1:0] ch;
        chreg_e     sel;
    } dec_t;

    // Highest base first: each window reaches up to the next base.
    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input logic full);
        dec_t              d;
        logic [ADDR_W-1:0] loc;
        d   = '{tgt: TGT_NONE, ch: 2'd0, sel: REG_PERIOD};
        loc = '0;
        if (a >= BASE_CH2) begin
            loc = a - BASE_CH2;
            if (full && loc < CH2_SPAN) begin
                d.tgt = TGT_CHAN;
                d.ch  = 2'd2;
                d.sel = chreg_e'(loc[3:2]);
            end
        end else if (a >= BASE_CH1) begin
            loc   = a - BASE_CH1;
            d.tgt = TGT_CHAN;
            d.ch  = 2'd1;
            d.sel = chreg_e'(loc[3:2]);
        end else if (a >= BASE_CH0) begin
            loc   = a - BASE_CH0;
            d.tgt = TGT_CHAN;
            d.ch  = 2'd0;
            d.sel = chreg_e'(loc[3:2]);
        end else if (a[ADDR_W-1:2] == 1) begin
            d.tgt = TGT_RUN;
        end else if (full) begin
            d.tgt = TGT_OUTCTL;
        end
        return d;
    endfunction

endpackage

// File: rtl/tmu_addr_dec.sv
module tmu_addr_dec
    import tmu_pkg::*;
#(
    parameter bit FULL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb dec = decode_addr(addr, FULL);
endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
    import tmu_pkg::*;
#(
    parameter int CW      = 32,
    parameter bit HAS_CAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr_en,
    input  chreg_e            sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [CW-1:0]     period_q, count_q;
    logic              ie_q, flag_q;
    logic [DATA_W-1:0] cap_q;
    logic              wr_period, wr_count, wr_ctrl, underflow;

    assign wr_period = wr_en && sel == REG_PERIOD;
    assign wr_count  = wr_en && sel == REG_COUNT;
    assign wr_ctrl   = wr_en && sel == REG_CTRL;
    assign underflow = run && count_q == '0 && !wr_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '1;
            count_q  <= '1;
            ie_q     <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_period) period_q <= CW'(wdata);
            if (wr_count)
                count_q <= CW'(wdata);
            else if (run)
                count_q <= (count_q == '0) ? period_q : count_q - 1'b1;
            if (wr_ctrl) begin
                ie_q <= wdata[IE_BIT];
                if (!wdata[FLAG_BIT]) flag_q <= 1'b0;
            end
            if (underflow) flag_q <= 1'b1;   // set beats clear
        end
    end

    generate
        if (HAS_CAP) begin : g_cap
            always_ff @(posedge clk) begin
                if (rst) cap_q <= '0;
                else if (wr_en && sel == REG_CAPTURE) cap_q <= wdata;
            end
        end else begin : g_nocap
            assign cap_q = '0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (sel)
            REG_PERIOD:  rdata = DATA_W'(period_q);
            REG_COUNT:   rdata = DATA_W'(count_q);
            REG_CTRL: begin
                rdata[IE_BIT]   = ie_q;
                rdata[FLAG_BIT] = flag_q;
            end
            default:     rdata = cap_q;
        endcase
    end

    assign irq = flag_q & ie_q;

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie_q);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !wr_ctrl) |=> flag_q);
    a_r6_frozen_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_count) |=> $stable(count_q));
    a_r5_reload_on_zero: assert property (@(posedge clk) disable iff (rst)
        underflow |=> (flag_q && count_q == $past(period_q)));
endmodule

// File: rtl/tmu_unit.sv
module tmu_unit
    import tmu_pkg::*;
#(
    parameter bit FULL = 1'b1,
    parameter int CW   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [MAX_CH-1:0] run_o,
    output logic [MAX_CH-1:0] irq_o,
    output logic              outctl_o
);
    localparam int NCH = FULL ? 3 : 2;

    dec_t              dec;
    logic [MAX_CH-1:0] run_q;
    logic              outctl_q;
    logic [DATA_W-1:0] ch_rd [MAX_CH];
    logic              run_bad, err_n, wr_run;
    logic [DATA_W-1:0] rd_mux;

    tmu_addr_dec #(.FULL(FULL)) u_dec (.addr(req_addr), .dec(dec));

    genvar gi;
    generate
        for (gi = 0; gi < MAX_CH; gi++) begin : g_ch
            if (gi < NCH) begin : g_on
                tmu_channel #(.CW(CW), .HAS_CAP(gi == 2)) u_ch (
                    .clk   (clk),
                    .rst   (rst),
                    .run   (run_q[gi]),
                    .wr_en (req_valid && req_write && dec.tgt == TGT_CHAN && dec.ch == gi),
                    .sel   (dec.sel),
                    .wdata (req_wdata),
                    .rdata (ch_rd[gi]),
                    .irq   (irq_o[gi])
                );
            end else begin : g_off
                assign ch_rd[gi] = '0;
                assign irq_o[gi] = 1'b0;
            end
        end
    endgenerate

    assign run_bad = !FULL && req_wdata[2];
    assign wr_run  = req_valid && req_write && dec.tgt == TGT_RUN;
    assign err_n   = req_valid && (dec.tgt == TGT_NONE || (wr_run && run_bad));

    always_comb begin
        rd_mux = '0;
        case (dec.tgt)
            TGT_OUTCTL: rd_mux[0] = outctl_q;
            TGT_RUN:    rd_mux[MAX_CH-1:0] = run_q;
            TGT_CHAN:   rd_mux = ch_rd[dec.ch];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            outctl_q  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            if (wr_run && !run_bad) run_q <= req_wdata[MAX_CH-1:0];
            if (req_valid && req_write && dec.tgt == TGT_OUTCTL) outctl_q <= req_wdata[0];
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write && !err_n) ? rd_mux : '0;
            rsp_err   <= err_n;
        end
    end

    assign run_o    = run_q;
    assign outctl_o = outctl_q;

    a_r12_rsp_from_read: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));
    a_r11_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_rdata == '0);
    a_r3_run_tracks_write: assert property (@(posedge clk) disable iff (rst)
        (wr_run && !run_bad) |=> run_o == $past(req_wdata[MAX_CH-1:0]));
    a_r10_reduced_no_ch2: assert property (@(posedge clk) disable iff (rst)
        !FULL |-> (run_o[2] == 1'b0 && irq_o[2] == 1'b0));
endmodule

// File: tb/tb_tmu_unit.sv
module tb_tmu_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        v1 = 0, w1 = 0, v2 = 0, w2 = 0;
    logic [7:0]  a1 = 0, a2 = 0;
    logic [31:0] d1 = 0, d2 = 0;
    logic        rv1, re1, rv2, re2, oc1, oc2;
    logic [31:0] rd1, rd2;
    logic [2:0]  run1, irq1, run2, irq2;

    tmu_unit #(.FULL(1'b1)) dut (
        .clk(clk), .rst(rst), .req_valid(v1), .req_write(w1), .req_addr(a1),
        .req_wdata(d1), .rsp_valid(rv1), .rsp_rdata(rd1), .rsp_err(re1),
        .run_o(run1), .irq_o(irq1), .outctl_o(oc1));

    tmu_unit #(.FULL(1'b0)) dut2 (
        .clk(clk), .rst(rst), .req_valid(v2), .req_write(w2), .req_addr(a2),
        .req_wdata(d2), .rsp_valid(rv2), .rsp_rdata(rd2), .rsp_err(re2),
        .run_o(run2), .irq_o(irq2), .outctl_o(oc2));

    int n_chk = 0, n_fail = 0;
    logic [31:0] r_d;
    logic        r_e, r_v;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one access, one clock edge; response sampled at the following falling edge
    task automatic acc(input bit which, input bit wr, input logic [7:0] ad, input logic [31:0] dat);
        if (!which) begin v1 = 1; w1 = wr; a1 = ad; d1 = dat; end
        else        begin v2 = 1; w2 = wr; a2 = ad; d2 = dat; end
        @(posedge clk);
        @(negedge clk);
        v1 = 0; v2 = 0;
        if (!which) begin r_d = rd1; r_e = re1; r_v = rv1; end
        else        begin r_d = rd2; r_e = re2; r_v = rv2; end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 run_o", {29'd0, run1}, 0);
        chk("R1 irq_o", {29'd0, irq1}, 0);
        chk("R1 outctl", {31'd0, oc1}, 0);
        acc(0, 0, 8'h04, 0); chk("R1 run reg", r_d, 0);
        acc(0, 0, 8'h08, 0); chk("R1 period ch0", r_d, 32'hFFFF_FFFF);
        acc(0, 0, 8'h24, 0); chk("R1 count ch2", r_d, 32'hFFFF_FFFF);
    endtask

    task automatic t_outctl;
        acc(0, 1, 8'h00, 32'hFFFF_FFFF); chk("R2 outctl pin", {31'd0, oc1}, 1);
        acc(0, 0, 8'h00, 0);             chk("R2 outctl read", r_d, 1);
        acc(0, 1, 8'h00, 32'h2);         acc(0, 0, 8'h00, 0);
        chk("R2 only bit0 kept", r_d, 0);
    endtask

    task automatic t_windows;
        acc(0, 1, 8'h08, 32'h1111_0008);
        acc(0, 1, 8'h14, 32'h2222_0014);
        acc(0, 1, 8'h20, 32'h3333_0020);
        acc(0, 1, 8'h2C, 32'hCAFE_0002);
        acc(0, 0, 8'h08, 0); chk("R4 ch0 period", r_d, 32'h1111_0008);
        acc(0, 0, 8'h14, 0); chk("R4 ch1 period", r_d, 32'h2222_0014);
        acc(0, 0, 8'h20, 0); chk("R4 ch2 period", r_d, 32'h3333_0020);
        acc(0, 0, 8'h2C, 0); chk("R4 ch2 capture", r_d, 32'hCAFE_0002);
        acc(0, 1, 8'h10, 32'hFFFF_FFFF); acc(0, 0, 8'h10, 0);
        chk("R7 ctrl reserved bits", r_d, 32'h20);
        acc(0, 1, 8'h10, 32'h0);
    endtask

    task automatic t_run_reg;
        acc(0, 1, 8'h04, 32'hFFFF_FFF5); chk("R3 run_o", {29'd0, run1}, 3'b101);
        acc(0, 0, 8'h04, 0);             chk("R3 run read", r_d, 5);
        acc(0, 1, 8'h04, 0);             chk("R3 run cleared", {29'd0, run1}, 0);
    endtask

    task automatic t_countdown;
        acc(0, 1, 8'h14, 5);            // ch1 period
        acc(0, 1, 8'h18, 3);            // ch1 count
        acc(0, 1, 8'h04, 32'h2);        // e0
        acc(0, 0, 8'h18, 0); chk("R12 read pre-edge count", r_d, 3);
        chk("R12 rsp_valid on read", {31'd0, r_v}, 1);
        idle(3);
        acc(0, 0, 8'h18, 0); chk("R5 reload after zero", r_d, 5);
        acc(0, 1, 8'h04, 0);
        chk("R12 no rsp_valid on write", {31'd0, r_v}, 0);
        acc(0, 0, 8'h1C, 0); chk("R5 flag set", r_d, 32'h100);
        acc(0, 1, 8'h1C, 0);
    endtask

    task automatic t_stop;
        acc(0, 1, 8'h0C, 100);
        acc(0, 1, 8'h04, 1);            // s0
        idle(9);
        acc(0, 1, 8'h04, 0);            // s10 last decrement
        acc(0, 0, 8'h0C, 0); chk("R6 frozen count", r_d, 90);
        idle(5);
        acc(0, 0, 8'h0C, 0); chk("R6 still frozen", r_d, 90);
        acc(0, 1, 8'h04, 1);
        idle(2);
        acc(0, 0, 8'h0C, 0); chk("R6 resume from frozen", r_d, 88);
        acc(0, 1, 8'h0C, 10);           // same edge as a decrement
        acc(0, 0, 8'h0C, 0); chk("R9 count write wins", r_d, 10);
        acc(0, 1, 8'h04, 0);
    endtask

    task automatic t_collision;
        acc(0, 1, 8'h20, 7);
        acc(0, 1, 8'h24, 2);
        acc(0, 1, 8'h04, 32'h4);        // e0
        idle(2);                        // e1, e2
        acc(0, 1, 8'h28, 32'h20);       // e3: underflow + clear
        chk("R8 irq after collision", {29'd0, irq1}, 3'b100);
        acc(0, 1, 8'h04, 0);
        acc(0, 0, 8'h28, 0); chk("R8 flag kept", r_d, 32'h120);
        acc(0, 1, 8'h28, 32'h120); chk("R7 bit8=1 keeps flag", {29'd0, irq1}, 3'b100);
        acc(0, 1, 8'h28, 32'h20);  chk("R7 bit8=0 clears", {29'd0, irq1}, 0);
    endtask

    task automatic t_unmapped;
        acc(0, 0, 8'h30, 0);
        chk("R11 err ch2 past window", {31'd0, r_e}, 1);
        chk("R11 data zero", r_d, 0);
        idle(1); chk("R11 err one cycle", {31'd0, re1}, 0);
    endtask

    task automatic t_reduced;
        acc(1, 1, 8'h04, 3);  chk("R10 run ok", {29'd0, run2}, 3'b011);
        acc(1, 1, 8'h04, 7);  chk("R10 run bit2 err", {31'd0, r_e}, 1);
        chk("R10 run unchanged", {29'd0, run2}, 3'b011);
        acc(1, 0, 8'h04, 0);  chk("R10 run read", r_d, 3);
        acc(1, 1, 8'h20, 5);  chk("R10 ch2 write err", {31'd0, r_e}, 1);
        acc(1, 0, 8'h24, 0);  chk("R10 ch2 read err", {31'd0, r_e}, 1);
        chk("R10 ch2 read zero", r_d, 0);
        acc(1, 1, 8'h00, 1);  chk("R10 outctl err", {31'd0, r_e}, 1);
        chk("R10 outctl pin", {31'd0, oc2}, 0);
        acc(1, 1, 8'h04, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset;
        t_outctl;
        t_windows;
        t_run_reg;
        t_countdown;
        t_stop;
        t_collision;
        t_unmapped;
        t_reduced;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule